// File: doc/BRIEF.md
# Bytecode to Simple-Operation Translator

This block sits between a bytecode fetch unit and a register-file/ALU back end. It takes a stream of 8-bit bytecode cells, one per accepted handshake, and turns each stack-machine instruction into one or more fixed 40-bit simple operations (SOPs). An SOP carries its operation code in bits 39:32. Its low 32 bits hold either four 8-bit parameter fields (p0 in bits 31:24, p1 in 23:16, p2 in 15:8, p3 in 7:0) or a single 32-bit literal. Register indices in the parameter fields address a 16-entry, 32-bit register file, so only their low nibble is meaningful.

Some instructions span several cells. Most opcodes expand into a fixed sequence read from a small microcode ROM. Each ROM word carries an end-of-sequence flag, and a per-opcode start-address table gives the entry point. Literal-push opcodes and unknown opcodes go through a control FSM instead. The FSM builds a single SOP from the opcode and its operand cells. Every SOP enters an output FIFO, which the consumer drains with a ready handshake and which reports empty and full.

Top module: `bcode_sop_xlate`

## Requirements
- R1: After reset the FIFO is empty (`sopEmpty`=1, `sopFull`=0) and `cellReady` is 1.
- R2: ROM-expanded bytecodes produce these exact sequences, in order. 0x60 gives 0x0201000000, 0x0200000000, 0x0400000100, 0x0300000000. 0x64 gives the same with a third word of 0x0400000101. 0x59 gives 0x0200000000, 0x0300000000, 0x0300000000. 0x57 gives 0x0200000000.
- R3: Bytecode 0x10 takes one operand cell and emits one SOP, 0x10 in the top byte with the operand sign-extended from 8 to 32 bits in the low 32 bits.
- R4: Bytecode 0x11 takes two operand cells, high byte first, and emits one SOP, 0x10 in the top byte with the 16-bit operand sign-extended to 32 bits.
- R5: Bytecodes 0x02 to 0x08 take no operand and emit one SOP, 0x10 in the top byte with the literal (opcode minus 3) as a 32-bit two's-complement value (-1 to 5).
- R6: Any other bytecode emits one trap SOP: 0xFF in the top byte, bits 31:8 zero and the offending opcode in bits 7:0.
- R7: `cellReady` is 0 while a sequence or a built SOP is still waiting to be emitted, and while the FIFO is full. No accepted cell is lost when the FIFO fills in the middle of a sequence.
- R8: SOPs leave in the order they were generated. `sopData` shows the oldest entry whenever `sopEmpty` is 0. An entry is removed on a clock edge with `sopReady`=1 and `sopEmpty`=0. `sopFull` is 1 exactly when the FIFO holds its depth of entries.
- R9: Bytecode 0x00 emits the single no-operation SOP 0x0100000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellValid | input | 1 | A bytecode cell is offered |
| cellData | input | 8 | Bytecode cell value |
| cellReady | output | 1 | Cell is taken on an edge when both valid and ready are 1 |
| sopData | output | 40 | Oldest queued SOP |
| sopEmpty | output | 1 | FIFO holds no SOP |
| sopFull | output | 1 | FIFO holds its full depth |
| sopReady | input | 1 | Consumer takes the oldest SOP |

## Verification
The main function is tried with one bytecode of each kind. There are ROM sequences of one, three and four words, and one-operand pushes with a positive and a negative byte. The two-operand pushes use positive and negative 16-bit values, including the 0x8000 corner, and the constant pushes cover both ends of the range. An unassigned opcode covers the trap path. Together these inputs show whether the ROM start table, the operand ordering and the sign extension are each right. A second pattern fills the FIFO partway through a multi-word sequence while another cell is held offered. It shows whether the stall, the pointer wrap-around and the order of the queued SOPs hold up under back-pressure.

// File: rtl/bcode_sop_pkg.sv
package bcode_sop_pkg;

  localparam int SOP_W   = 40;
  localparam int ROM_DEP = 16;
  localparam int ROM_AW  = $clog2(ROM_DEP);

  localparam logic [7:0] SOP_NOP  = 8'h01;
  localparam logic [7:0] SOP_POPR = 8'h02;
  localparam logic [7:0] SOP_PSHR = 8'h03;
  localparam logic [7:0] SOP_ALU  = 8'h04;
  localparam logic [7:0] SOP_LIT  = 8'h10;
  localparam logic [7:0] SOP_TRAP = 8'hFF;

  localparam logic [7:0] FN_ADD = 8'h00;
  localparam logic [7:0] FN_SUB = 8'h01;

  typedef enum logic [2:0] {
    CLS_ROM, CLS_LIT8, CLS_LIT16, CLS_CONST, CLS_TRAP
  } bcClass_e;

  typedef struct packed {
    logic     loadOp;
    logic     shiftOpnd;
    logic     romLoad;
    logic     romStep;
    logic     pushSop;
    logic     selRom;
    bcClass_e litKind;
  } ctrlStrobe_t;

  function automatic bcClass_e classify(input logic [7:0] op);
    case (op)
      8'h00, 8'h57, 8'h59, 8'h60, 8'h64: classify = CLS_ROM;
      8'h10:                             classify = CLS_LIT8;
      8'h11:                             classify = CLS_LIT16;
      8'h02, 8'h03, 8'h04, 8'h05,
      8'h06, 8'h07, 8'h08:               classify = CLS_CONST;
      default:                           classify = CLS_TRAP;
    endcase
  endfunction

  function automatic logic [ROM_AW-1:0] romStart(input logic [7:0] op);
    case (op)
      8'h60:   romStart = ROM_AW'(1);
      8'h64:   romStart = ROM_AW'(5);
      8'h59:   romStart = ROM_AW'(9);
      8'h57:   romStart = ROM_AW'(12);
      default: romStart = ROM_AW'(0);
    endcase
  endfunction

  function automatic logic [SOP_W-1:0] mkSop(input logic [7:0] code, input logic [7:0] p0,
                                             input logic [7:0] p1, input logic [7:0] p2,
                                             input logic [7:0] p3);
    mkSop = {code, p0, p1, p2, p3};
  endfunction

  // ROM word: {endOfSequence, sop}
  function automatic logic [SOP_W:0] romWord(input logic [ROM_AW-1:0] addr);
    case (addr)
      ROM_AW'(0):  romWord = {1'b1, mkSop(SOP_NOP,  8'd0, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(1):  romWord = {1'b0, mkSop(SOP_POPR, 8'd1, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(2):  romWord = {1'b0, mkSop(SOP_POPR, 8'd0, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(3):  romWord = {1'b0, mkSop(SOP_ALU,  8'd0, 8'd0, 8'd1, FN_ADD)};
      ROM_AW'(4):  romWord = {1'b1, mkSop(SOP_PSHR, 8'd0, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(5):  romWord = {1'b0, mkSop(SOP_POPR, 8'd1, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(6):  romWord = {1'b0, mkSop(SOP_POPR, 8'd0, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(7):  romWord = {1'b0, mkSop(SOP_ALU,  8'd0, 8'd0, 8'd1, FN_SUB)};
      ROM_AW'(8):  romWord = {1'b1, mkSop(SOP_PSHR, 8'd0, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(9):  romWord = {1'b0, mkSop(SOP_POPR, 8'd0, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(10): romWord = {1'b0, mkSop(SOP_PSHR, 8'd0, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(11): romWord = {1'b1, mkSop(SOP_PSHR, 8'd0, 8'd0, 8'd0, 8'd0)};
      ROM_AW'(12): romWord = {1'b1, mkSop(SOP_POPR, 8'd0, 8'd0, 8'd0, 8'd0)};
      default:     romWord = {1'b1, mkSop(SOP_NOP,  8'd0, 8'd0, 8'd0, 8'd0)};
    endcase
  endfunction

endpackage

// File: rtl/bcode_sop_fifo.sv
module bcode_sop_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdReq,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             rdEn;

  assign empty  = (count == '0);
  assign full   = (count == FULL_CNT);
  assign rdEn   = rdReq && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + AW'(1);
      if (rdEn) rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + AW'(1);
      case ({wrEn, rdEn})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  // R8: the producer never writes into a full queue
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !full);
  // R8: a write without a read leaves the queue non-empty
  assert_push_not_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn) |=> !empty);
endmodule

// File: rtl/bcode_sop_ctrl.sv
module bcode_sop_ctrl
  import bcode_sop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cellValid,
  input  logic [7:0]  cellData,
  output logic        cellReady,
  input  logic        romLast,
  input  logic        fifoFull,
  output ctrlStrobe_t strb
);
  typedef enum logic [2:0] {ST_IDLE, ST_OPND1, ST_OPND2, ST_ROM, ST_EMIT} state_e;

  state_e   state, stateNext;
  bcClass_e clsQ;
  bcClass_e cellCls;
  logic     cellAccept;

  assign cellCls    = classify(cellData);
  assign cellReady  = ((state == ST_IDLE) || (state == ST_OPND1) || (state == ST_OPND2))
                      && !fifoFull;
  assign cellAccept = cellValid && cellReady;

  always_comb begin
    strb         = '0;
    strb.litKind = clsQ;
    strb.selRom  = (state == ST_ROM);
    stateNext    = state;
    case (state)
      ST_IDLE: if (cellAccept) begin
        strb.loadOp = 1'b1;
        case (cellCls)
          CLS_ROM: begin
            strb.romLoad = 1'b1;
            stateNext    = ST_ROM;
          end
          CLS_LIT8, CLS_LIT16: stateNext = ST_OPND1;
          default:             stateNext = ST_EMIT;
        endcase
      end
      ST_OPND1: if (cellAccept) begin
        strb.shiftOpnd = 1'b1;
        stateNext      = (clsQ == CLS_LIT16) ? ST_OPND2 : ST_EMIT;
      end
      ST_OPND2: if (cellAccept) begin
        strb.shiftOpnd = 1'b1;
        stateNext      = ST_EMIT;
      end
      ST_EMIT: if (!fifoFull) begin
        strb.pushSop = 1'b1;
        stateNext    = ST_IDLE;
      end
      ST_ROM: if (!fifoFull) begin
        strb.pushSop = 1'b1;
        if (romLast) stateNext = ST_IDLE;
        else         strb.romStep = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      clsQ  <= CLS_ROM;
    end else begin
      state <= stateNext;
      if (strb.loadOp) clsQ <= cellCls;
    end
  end

  // R7: taking a ROM-expanded opcode closes the cell input on the next cycle
  assert_busy_after_rom_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cellAccept && cellCls == CLS_ROM) |=> !cellReady);
  // R7: a built SOP waiting on a full queue stays pending
  assert_emit_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMIT && fifoFull) |=> (state == ST_EMIT));
endmodule

// File: rtl/bcode_sop_dp.sv
module bcode_sop_dp
  import bcode_sop_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       cellData,
  input  ctrlStrobe_t      strb,
  output logic             romLast,
  output logic             fifoFull,
  output logic [SOP_W-1:0] sopData,
  output logic             sopEmpty,
  input  logic             sopReady
);
  logic [7:0]        opQ;
  logic [15:0]       opndQ;
  logic [ROM_AW-1:0] romAddr;
  logic [SOP_W:0]    romOut;
  logic [SOP_W-1:0]  customSop, sopIn;

  assign romOut  = romWord(romAddr);
  assign romLast = romOut[SOP_W];

  always_comb begin
    case (strb.litKind)
      CLS_LIT8:  customSop = {SOP_LIT, {24{opndQ[7]}}, opndQ[7:0]};
      CLS_LIT16: customSop = {SOP_LIT, {16{opndQ[15]}}, opndQ};
      CLS_CONST: customSop = {SOP_LIT, {24'h0, opQ} - 32'd3};
      default:   customSop = {SOP_TRAP, 24'h0, opQ};
    endcase
  end

  assign sopIn = strb.selRom ? romOut[SOP_W-1:0] : customSop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= '0;
      opndQ   <= '0;
      romAddr <= '0;
    end else begin
      if (strb.loadOp)    opQ   <= cellData;
      if (strb.shiftOpnd) opndQ <= {opndQ[7:0], cellData};
      if (strb.romLoad)      romAddr <= romStart(cellData);
      else if (strb.romStep) romAddr <= romAddr + ROM_AW'(1);
    end
  end

  bcode_sop_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SOP_W)) u_fifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strb.pushSop),
    .wrData (sopIn),
    .rdReq  (sopReady),
    .rdData (sopData),
    .empty  (sopEmpty),
    .full   (fifoFull)
  );

  // R3: a one-byte literal reaches the queue sign-extended
  assert_lit8_sext_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushSop && !strb.selRom && strb.litKind == CLS_LIT8)
      |-> (sopIn[31:8] == {24{sopIn[7]}}));
  // R4: a two-byte literal reaches the queue sign-extended
  assert_lit16_sext_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushSop && !strb.selRom && strb.litKind == CLS_LIT16)
      |-> (sopIn[31:16] == {16{sopIn[15]}}));
  // R6: a trap word carries only the opcode in its low byte
  assert_trap_shape_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushSop && sopIn[39:32] == SOP_TRAP) |-> (sopIn[31:8] == 24'h0));
endmodule

// File: rtl/bcode_sop_xlate.sv
module bcode_sop_xlate
  import bcode_sop_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cellValid,
  input  logic [7:0]  cellData,
  output logic        cellReady,
  output logic [39:0] sopData,
  output logic        sopEmpty,
  output logic        sopFull,
  input  logic        sopReady
);
  ctrlStrobe_t strb;
  logic        romLast;
  logic        fifoFull;

  assign sopFull = fifoFull;

  bcode_sop_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cellValid (cellValid),
    .cellData  (cellData),
    .cellReady (cellReady),
    .romLast   (romLast),
    .fifoFull  (fifoFull),
    .strb      (strb)
  );

  bcode_sop_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cellData (cellData),
    .strb     (strb),
    .romLast  (romLast),
    .fifoFull (fifoFull),
    .sopData  (sopData),
    .sopEmpty (sopEmpty),
    .sopReady (sopReady)
  );
endmodule

// File: tb/bcode_sop_xlate_bench.sv
`timescale 1ns/1ps
module bcode_sop_xlate_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cellValid = 1'b0;
  logic [7:0]  cellData = 8'h00;
  logic        cellReady;
  logic [39:0] sopData;
  logic        sopEmpty, sopFull;
  logic        sopReady = 1'b0;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  bcode_sop_xlate u_bcode_sop_xlate (
    .clk(clk), .rstN(rstN), .cellValid(cellValid), .cellData(cellData),
    .cellReady(cellReady), .sopData(sopData), .sopEmpty(sopEmpty),
    .sopFull(sopFull), .sopReady(sopReady)
  );

  localparam logic [39:0] S_NOP  = 40'h01_0000_0000;
  localparam logic [39:0] S_POP1 = 40'h02_0100_0000;
  localparam logic [39:0] S_POP0 = 40'h02_0000_0000;
  localparam logic [39:0] S_PSH0 = 40'h03_0000_0000;
  localparam logic [39:0] S_ADD  = 40'h04_0000_0100;
  localparam logic [39:0] S_SUB  = 40'h04_0000_0101;

  localparam int NV = 13;
  localparam logic [7:0] V_CELL [NV][3] = '{
    '{8'h00, 8'h00, 8'h00},  // R9 no-op
    '{8'h60, 8'h00, 8'h00},  // R2 add
    '{8'h64, 8'h00, 8'h00},  // R2 sub
    '{8'h59, 8'h00, 8'h00},  // R2 dup
    '{8'h57, 8'h00, 8'h00},  // R2 pop
    '{8'h10, 8'h05, 8'h00},  // R3 positive byte
    '{8'h10, 8'h80, 8'h00},  // R3 negative byte
    '{8'h11, 8'h12, 8'h34},  // R4 positive halfword
    '{8'h11, 8'hFF, 8'hFE},  // R4 negative halfword
    '{8'h11, 8'h80, 8'h00},  // R4 most negative halfword
    '{8'h02, 8'h00, 8'h00},  // R5 lowest constant
    '{8'h08, 8'h00, 8'h00},  // R5 highest constant
    '{8'hC8, 8'h00, 8'h00}   // R6 unassigned opcode
  };
  localparam int V_NC [NV] = '{1, 1, 1, 1, 1, 2, 2, 3, 3, 3, 1, 1, 1};
  localparam logic [39:0] V_SOP [NV][4] = '{
    '{S_NOP, 40'h0, 40'h0, 40'h0},
    '{S_POP1, S_POP0, S_ADD, S_PSH0},
    '{S_POP1, S_POP0, S_SUB, S_PSH0},
    '{S_POP0, S_PSH0, S_PSH0, 40'h0},
    '{S_POP0, 40'h0, 40'h0, 40'h0},
    '{40'h10_0000_0005, 40'h0, 40'h0, 40'h0},
    '{40'h10_FFFF_FF80, 40'h0, 40'h0, 40'h0},
    '{40'h10_0000_1234, 40'h0, 40'h0, 40'h0},
    '{40'h10_FFFF_FFFE, 40'h0, 40'h0, 40'h0},
    '{40'h10_FFFF_8000, 40'h0, 40'h0, 40'h0},
    '{40'h10_FFFF_FFFF, 40'h0, 40'h0, 40'h0},
    '{40'h10_0000_0005, 40'h0, 40'h0, 40'h0},
    '{40'hFF_0000_00C8, 40'h0, 40'h0, 40'h0}
  };
  localparam int V_NS [NV] = '{1, 4, 4, 3, 1, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam string V_REQ [NV] = '{"R9", "R2", "R2", "R2", "R2", "R3", "R3",
                                   "R4", "R4", "R4", "R5", "R5", "R6"};

  localparam int NF = 12;
  localparam logic [39:0] F_SOP [NF] = '{
    S_POP1, S_POP0, S_ADD, S_PSH0, S_POP0, S_PSH0, S_PSH0,
    S_POP1, S_POP0, S_SUB, S_PSH0, 40'h10_FFFF_FFFF
  };

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendCell(input logic [7:0] b);
    @(negedge clk);
    while (!cellReady) @(negedge clk);
    cellValid = 1'b1;
    cellData  = b;
    @(negedge clk);
    cellValid = 1'b0;
  endtask

  task automatic popCheck(input string req, input logic [39:0] exp);
    @(negedge clk);
    while (sopEmpty) @(negedge clk);
    check(req, sopData, exp);
    sopReady = 1'b1;
    @(negedge clk);
    sopReady = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", 40'(sopEmpty), 40'd1);
    check("R1 full", 40'(sopFull), 40'd0);
    check("R1 ready", 40'(cellReady), 40'd1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < V_NC[v]; c++) sendCell(V_CELL[v][c]);
      for (int s = 0; s < V_NS[v]; s++) popCheck(V_REQ[v], V_SOP[v][s]);
      repeat (2) @(negedge clk);
      check({V_REQ[v], " drained"}, 40'(sopEmpty), 40'd1);
    end

    // R7: input closes while a ROM sequence is being emitted
    sendCell(8'h60);
    check("R7 busy during sequence", 40'(cellReady), 40'd0);
    for (int s = 0; s < 4; s++) popCheck("R2 add again", V_SOP[1][s]);

    // R7/R8: fill the queue in the middle of a sequence, with a cell held offered
    sendCell(8'h60);
    sendCell(8'h59);
    sendCell(8'h64);
    fork
      sendCell(8'h02);
    join_none
    repeat (6) @(negedge clk);
    check("R8 full flag", 40'(sopFull), 40'd1);
    check("R7 ready low when full", 40'(cellReady), 40'd0);
    check("R8 head stays oldest", sopData, S_POP1);
    for (int i = 0; i < NF; i++) popCheck("R8 order under stall", F_SOP[i]);
    repeat (3) @(negedge clk);
    check("R8 empty after drain", 40'(sopEmpty), 40'd1);
    check("R8 not full after drain", 40'(sopFull), 40'd0);
    check("R7 ready after drain", 40'(cellReady), 40'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule